// File: doc/BRIEF.md
# Audio Ring Buffer Pointer Tracker

This block keeps the pointer bookkeeping for one circular audio buffer held in system memory. Software programs the buffer's first and last byte addresses, a watermark and both pointers through a small register-load port. The streaming side then moves the one pointer the hardware owns: the read pointer on a playback channel or the write pointer on a capture channel. It moves that pointer in whole 32-bit words. The data transfers themselves happen elsewhere; this block only tracks where they are.

Each pointer is one bit wider than the byte address. The extra top bit toggles every time the pointer wraps, so equal addresses can be told apart as empty or full. From the two pointers the block derives the filled and free byte counts, full and empty flags, and the hardware pointer's offset from the buffer base. A playback channel compares its free space with the watermark, and a capture channel compares its filled space. When the watched count goes strictly above the watermark, an event is raised and held until software rearms it. A request to move more bytes than are available is refused and recorded as an underrun (playback) or overrun (capture).

The parameter `IS_PLAY` picks the channel kind at elaboration. Software refills a playback buffer by writing the write pointer equal to the read pointer with its top bit inverted. It drains a capture buffer by writing the read pointer equal to the write pointer.

Top module: `rbt_ring_tracker`

## Requirements
- R1: During reset, both pointers, the base, the last-byte address and the watermark are zero. `buf_empty` is 1, `buf_full` is 0, `fill_bytes` is 0, and `mark_hit` and `xrun` are 0.
- R2: The pointers are `ADDR_W+1` bits wide, and the top bit (bit 31 by default) is the wrap toggle. `buf_empty` is 1 when the two pointers are equal in every bit. `buf_full` is 1 when their address bits match and their top bits differ.
- R3: When the hardware pointer's address would step past the last-byte address, it continues from the base address and its top bit inverts. A step that lands exactly one past the last byte gives the base address with the top bit inverted.
- R4: An accepted advance of N words moves the hardware pointer by 4·N bytes and leaves the other pointer unchanged. On a playback channel the hardware pointer is the read pointer; on a capture channel it is the write pointer. Pointer outputs show the new value in the cycle after the accepting edge.
- R5: `fill_bytes` equals write address − read address when the top bits match, and size − (read address − write address) when they differ, where size = last − base + 1. `free_bytes` equals size − `fill_bytes`.
- R6: The watched count is `free_bytes` for playback and `fill_bytes` for capture. `mark_hit` rises one cycle after that count becomes strictly greater than the watermark. The low 8 bits of the loaded watermark are ignored, so the threshold is always a multiple of 256 bytes.
- R7: Once set, `mark_hit` stays 1 until a `rearm` pulse. The rearm edge clears it. If the watched count is still above the watermark, it sets again on the following edge.
- R8: `adv_ready` is 1 only when the requested bytes do not exceed the available bytes: filled bytes for playback, free bytes for capture. A request exactly equal to the available bytes is accepted. A refused request leaves the pointer unchanged and sets `xrun`, which stays 1 until a `rearm` pulse.
- R9: A register load takes effect on the next edge at any time. Select codes are 0 base, 1 last-byte address, 2 watermark, 3 read pointer, 4 write pointer; other codes change nothing. In a cycle with `cfg_we` high, `adv_ready` is 0 and no advance takes place.
- R10: `cur_offset` equals the hardware pointer's address bits minus the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register load strobe |
| cfg_sel | input | 3 | Register select code (see R9) |
| cfg_data | input | ADDR_W+1 | Load value; the top bit is used only for pointers |
| rearm | input | 1 | Clears the watermark event and the underrun/overrun flag |
| adv_valid | input | 1 | Advance request from the stream side |
| adv_words | input | WORDS_W | Number of 32-bit words to advance |
| adv_ready | output | 1 | Request can be taken this cycle |
| rd_ptr | output | ADDR_W+1 | Read pointer with wrap toggle |
| wr_ptr | output | ADDR_W+1 | Write pointer with wrap toggle |
| fill_bytes | output | ADDR_W+1 | Bytes held in the buffer |
| free_bytes | output | ADDR_W+1 | Bytes of free space |
| buf_empty | output | 1 | Pointers equal in every bit |
| buf_full | output | 1 | Addresses equal, top bits differ |
| xrun | output | 1 | Sticky underrun (playback) or overrun (capture) |
| mark_hit | output | 1 | Latched watermark event |
| cur_offset | output | ADDR_W | Hardware pointer offset from base |

## Verification
The pointer-range property assumes that base ≤ last and that the hardware pointer already lies inside the buffer when an advance is taken. The stimulus loads a consistent base, last-byte address and pointer pair before any advance. The level arithmetic is meaningful only while both pointers sit inside the buffer and the filled count does not exceed the size. The bench therefore refills or drains only by the pointer rewrites that software would use. The stall and flag properties assume a stream side that holds `adv_words` stable while `adv_valid` is high. The bench drives each request for exactly one cycle.

// File: rtl/rbt_pkg.sv
package rbt_pkg;
   typedef enum logic [2:0] {
      SEL_BASE = 3'd0,
      SEL_LAST = 3'd1,
      SEL_MARK = 3'd2,
      SEL_RD   = 3'd3,
      SEL_WR   = 3'd4
   } cfg_sel_e;
endpackage

// File: rtl/rbt_ptr_step.sv
// Advances a wrap-tagged pointer by a byte count inside [base, last].
module rbt_ptr_step #(
   parameter int ADDR_W = 31,
   localparam int PTR_W = ADDR_W + 1,
   localparam int LVL_W = ADDR_W + 1
) (
   input  logic [PTR_W-1:0]  cur,
   input  logic [LVL_W-1:0]  step,
   input  logic [ADDR_W-1:0] last,
   input  logic [LVL_W-1:0]  size,
   output logic [PTR_W-1:0]  nxt
);
   logic [LVL_W:0] sum;
   logic [LVL_W:0] wrapped;
   logic           past_last;

   always_comb begin
      sum       = {2'b00, cur[ADDR_W-1:0]} + {1'b0, step};
      past_last = sum > {2'b00, last};
      wrapped   = sum - {1'b0, size};
      if (past_last) begin
         nxt = {~cur[ADDR_W], wrapped[ADDR_W-1:0]};
      end else begin
         nxt = {cur[ADDR_W], sum[ADDR_W-1:0]};
      end
   end
endmodule

// File: rtl/rbt_level.sv
// Filled / free byte counts and full / empty from the two pointers.
module rbt_level #(
   parameter int ADDR_W = 31,
   localparam int PTR_W = ADDR_W + 1,
   localparam int LVL_W = ADDR_W + 1
) (
   input  logic [PTR_W-1:0] rd,
   input  logic [PTR_W-1:0] wr,
   input  logic [LVL_W-1:0] size,
   output logic [LVL_W-1:0] fill,
   output logic [LVL_W-1:0] free,
   output logic             empty,
   output logic             full
);
   logic same_lap;
   logic addr_eq;

   always_comb begin
      same_lap = rd[ADDR_W] == wr[ADDR_W];
      addr_eq  = rd[ADDR_W-1:0] == wr[ADDR_W-1:0];
      if (same_lap) begin
         fill = {1'b0, wr[ADDR_W-1:0]} - {1'b0, rd[ADDR_W-1:0]};
      end else begin
         fill = size - ({1'b0, rd[ADDR_W-1:0]} - {1'b0, wr[ADDR_W-1:0]});
      end
      free  = size - fill;
      empty = same_lap && addr_eq;
      full  = !same_lap && addr_eq;
   end
endmodule

// File: rtl/rbt_mark.sv
// Watermark comparator with a latched event cleared by rearm.
module rbt_mark #(
   parameter int ADDR_W    = 31,
   parameter int GRAN_LOG2 = 8,
   localparam int LVL_W    = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  watched,
   input  logic [ADDR_W-1:0] mark_raw,
   input  logic              rearm,
   output logic              hit
);
   logic [ADDR_W-1:0] mark_eff;
   logic              above;

   assign mark_eff = {mark_raw[ADDR_W-1:GRAN_LOG2], {GRAN_LOG2{1'b0}}};
   assign above    = watched > {1'b0, mark_eff};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit <= 1'b0;
      end else if (rearm) begin
         hit <= 1'b0;
      end else if (above) begin
         hit <= 1'b1;
      end
   end

   p_mark_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !rearm |=> hit);
   p_mark_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rearm |=> !hit);
   p_mark_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hit) |-> $past(watched > {1'b0, mark_eff}));
endmodule

// File: rtl/rbt_ring_tracker.sv
module rbt_ring_tracker #(
   parameter int ADDR_W    = 31,
   parameter int WORDS_W   = 8,
   parameter int GRAN_LOG2 = 8,
   parameter bit IS_PLAY   = 1'b1,
   localparam int PTR_W    = ADDR_W + 1,
   localparam int LVL_W    = ADDR_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_sel,
   input  logic [PTR_W-1:0]   cfg_data,
   input  logic               rearm,
   input  logic               adv_valid,
   input  logic [WORDS_W-1:0] adv_words,
   output logic               adv_ready,
   output logic [PTR_W-1:0]   rd_ptr,
   output logic [PTR_W-1:0]   wr_ptr,
   output logic [LVL_W-1:0]   fill_bytes,
   output logic [LVL_W-1:0]   free_bytes,
   output logic               buf_empty,
   output logic               buf_full,
   output logic               xrun,
   output logic               mark_hit,
   output logic [ADDR_W-1:0]  cur_offset
);
   import rbt_pkg::*;

   if (ADDR_W < GRAN_LOG2 + 1 || ADDR_W > 31) begin : g_bad_addr
      $error("rbt_ring_tracker: ADDR_W out of range");
   end
   if (WORDS_W + 2 >= LVL_W) begin : g_bad_words
      $error("rbt_ring_tracker: WORDS_W too wide for ADDR_W");
   end

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] last_q;
   logic [ADDR_W-1:0] mark_q;
   logic [PTR_W-1:0]  rd_q;
   logic [PTR_W-1:0]  wr_q;
   logic              xrun_q;

   logic [LVL_W-1:0]  size;
   logic [LVL_W-1:0]  step_bytes;
   logic [LVL_W-1:0]  avail;
   logic [LVL_W-1:0]  watched;
   logic [PTR_W-1:0]  hw_ptr;
   logic [PTR_W-1:0]  sw_ptr;
   logic [PTR_W-1:0]  hw_nxt;
   logic              enough;
   logic              accept;

   assign size       = {1'b0, last_q} - {1'b0, base_q} + 1'b1;
   assign step_bytes = {{(LVL_W-WORDS_W-2){1'b0}}, adv_words, 2'b00};

   rbt_level #(.ADDR_W(ADDR_W)) u_level (
      .rd    (rd_q),
      .wr    (wr_q),
      .size  (size),
      .fill  (fill_bytes),
      .free  (free_bytes),
      .empty (buf_empty),
      .full  (buf_full)
   );

   if (IS_PLAY) begin : g_play
      assign hw_ptr  = rd_q;
      assign sw_ptr  = wr_q;
      assign avail   = fill_bytes;
      assign watched = free_bytes;
   end else begin : g_cap
      assign hw_ptr  = wr_q;
      assign sw_ptr  = rd_q;
      assign avail   = free_bytes;
      assign watched = fill_bytes;
   end

   rbt_ptr_step #(.ADDR_W(ADDR_W)) u_step (
      .cur  (hw_ptr),
      .step (step_bytes),
      .last (last_q),
      .size (size),
      .nxt  (hw_nxt)
   );

   assign enough    = step_bytes <= avail;
   assign adv_ready = enough && !cfg_we;
   assign accept    = adv_valid && adv_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         last_q <= '0;
         mark_q <= '0;
         rd_q   <= '0;
         wr_q   <= '0;
      end else if (cfg_we) begin
         case (cfg_sel_e'(cfg_sel))
            SEL_BASE: base_q <= cfg_data[ADDR_W-1:0];
            SEL_LAST: last_q <= cfg_data[ADDR_W-1:0];
            SEL_MARK: mark_q <= cfg_data[ADDR_W-1:0];
            SEL_RD:   rd_q   <= cfg_data;
            SEL_WR:   wr_q   <= cfg_data;
            default:  ;
         endcase
      end else if (accept) begin
         if (IS_PLAY) rd_q <= hw_nxt;
         else         wr_q <= hw_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xrun_q <= 1'b0;
      end else if (rearm) begin
         xrun_q <= 1'b0;
      end else if (adv_valid && !cfg_we && !enough) begin
         xrun_q <= 1'b1;
      end
   end

   rbt_mark #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_mark (
      .clk      (clk),
      .rst_n    (rst_n),
      .watched  (watched),
      .mark_raw (mark_q),
      .rearm    (rearm),
      .hit      (mark_hit)
   );

   assign rd_ptr     = rd_q;
   assign wr_ptr     = wr_q;
   assign xrun       = xrun_q;
   assign cur_offset = hw_ptr[ADDR_W-1:0] - base_q;

   p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept && base_q <= last_q && hw_ptr[ADDR_W-1:0] >= base_q
      && hw_ptr[ADDR_W-1:0] <= last_q
      |=> hw_ptr[ADDR_W-1:0] >= base_q && hw_ptr[ADDR_W-1:0] <= last_q);
   p_other_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> $stable(sw_ptr));
   p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      adv_valid && !adv_ready && !cfg_we |=> $stable(hw_ptr));
   p_xrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      adv_valid && !adv_ready && !cfg_we && !rearm |=> xrun);
   p_cfg_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |-> !adv_ready);
endmodule

// File: tb/rbt_ring_tracker_tb.sv
module rbt_ring_tracker_tb;
   localparam logic [31:0] TOP = 32'h8000_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        p_we = 0, p_rearm = 0, p_valid = 0;
   logic [2:0]  p_sel = 0;
   logic [31:0] p_data = 0;
   logic [7:0]  p_words = 0;
   logic        p_ready, p_empty, p_full, p_xrun, p_hit;
   logic [31:0] p_rd, p_wr, p_fill, p_free;
   logic [30:0] p_off;

   logic        c_we = 0, c_rearm = 0, c_valid = 0;
   logic [2:0]  c_sel = 0;
   logic [31:0] c_data = 0;
   logic [7:0]  c_words = 0;
   logic        c_ready, c_empty, c_full, c_xrun, c_hit;
   logic [31:0] c_rd, c_wr, c_fill, c_free;
   logic [30:0] c_off;

   rbt_ring_tracker #(.IS_PLAY(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(p_we), .cfg_sel(p_sel), .cfg_data(p_data),
      .rearm(p_rearm), .adv_valid(p_valid), .adv_words(p_words), .adv_ready(p_ready),
      .rd_ptr(p_rd), .wr_ptr(p_wr), .fill_bytes(p_fill), .free_bytes(p_free),
      .buf_empty(p_empty), .buf_full(p_full), .xrun(p_xrun), .mark_hit(p_hit),
      .cur_offset(p_off));

   rbt_ring_tracker #(.IS_PLAY(1'b0)) u_dut_cap (
      .clk(clk), .rst_n(rst_n), .cfg_we(c_we), .cfg_sel(c_sel), .cfg_data(c_data),
      .rearm(c_rearm), .adv_valid(c_valid), .adv_words(c_words), .adv_ready(c_ready),
      .rd_ptr(c_rd), .wr_ptr(c_wr), .fill_bytes(c_fill), .free_bytes(c_free),
      .buf_empty(c_empty), .buf_full(c_full), .xrun(c_xrun), .mark_hit(c_hit),
      .cur_offset(c_off));

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // Arithmetic model of the requirements.
   function automatic logic [31:0] m_fill(input logic [31:0] rd, input logic [31:0] wr,
                                          input logic [31:0] sz);
      if (rd[31] == wr[31]) return {1'b0, wr[30:0]} - {1'b0, rd[30:0]};
      return sz - ({1'b0, rd[30:0]} - {1'b0, wr[30:0]});
   endfunction

   function automatic logic [31:0] m_step(input logic [31:0] p, input logic [31:0] bytes,
                                          input logic [31:0] base, input logic [31:0] last);
      logic [31:0] a;
      a = {1'b0, p[30:0]} + bytes;
      if (a > last) return {~p[31], 31'(a - (last - base + 1))};
      return {p[31], a[30:0]};
   endfunction

   task automatic pcfg(input logic [2:0] s, input logic [31:0] d);
      p_we = 1; p_sel = s; p_data = d;
      @(negedge clk);
      p_we = 0;
   endtask
   task automatic ccfg(input logic [2:0] s, input logic [31:0] d);
      c_we = 1; c_sel = s; c_data = d;
      @(negedge clk);
      c_we = 0;
   endtask
   task automatic padv(input int n);
      p_valid = 1; p_words = 8'(n);
      @(negedge clk);
      p_valid = 0;
   endtask
   task automatic cadv(input int n);
      c_valid = 1; c_words = 8'(n);
      @(negedge clk);
      c_valid = 0;
   endtask
   task automatic prearm();
      p_rearm = 1; @(negedge clk); p_rearm = 0;
   endtask
   task automatic crearm();
      c_rearm = 1; @(negedge clk); c_rearm = 0;
   endtask

   initial begin
      #(20ns * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] mrd, mwr, mf;
      repeat (3) @(negedge clk);
      // R1 reset state, sampled with reset held
      chk("R1 p_rd", p_rd, 0);        chk("R1 p_wr", p_wr, 0);
      chk("R1 p_empty", 32'(p_empty), 1); chk("R1 p_full", 32'(p_full), 0);
      chk("R1 p_fill", p_fill, 0);    chk("R1 p_hit", 32'(p_hit), 0);
      chk("R1 p_xrun", 32'(p_xrun), 0);
      chk("R1 c_empty", 32'(c_empty), 1); chk("R1 c_hit", 32'(c_hit), 0);
      rst_n = 1;

      // ---------------- playback channel ----------------
      pcfg(3'd0, 32'h1000); pcfg(3'd1, 32'h13FF); pcfg(3'd2, 32'h100);
      pcfg(3'd3, 32'h1000); pcfg(3'd4, TOP | 32'h1000);
      chk("R2 full", 32'(p_full), 1);   chk("R2 not empty", 32'(p_empty), 0);
      chk("R5 fill", p_fill, 1024);     chk("R5 free", p_free, 0);
      prearm();
      @(negedge clk);
      chk("R6 no mark at free 0", 32'(p_hit), 0);
      padv(64);
      chk("R4 rd moved", p_rd, 32'h1100); chk("R4 wr held", p_wr, TOP | 32'h1000);
      @(negedge clk);
      chk("R6 free equal to mark no event", 32'(p_hit), 0);
      padv(1);
      chk("R5 free 260", p_free, 260);
      @(negedge clk);
      chk("R6 free above mark event", 32'(p_hit), 1);
      padv(1);
      @(negedge clk);
      chk("R7 stays latched", 32'(p_hit), 1);
      prearm();
      chk("R7 rearm clears", 32'(p_hit), 0);
      @(negedge clk);
      chk("R7 refires while above", 32'(p_hit), 1);
      chk("R10 offset", 32'(p_off), 32'h108);
      chk("R5 fill 760", p_fill, 760);

      // R9: load and advance in the same cycle
      p_we = 1; p_sel = 3'd4; p_data = TOP | 32'h1108; p_valid = 1; p_words = 1;
      #1 chk("R9 ready low during load", 32'(p_ready), 0);
      @(negedge clk);
      p_we = 0; p_valid = 0;
      chk("R9 rd not advanced", p_rd, 32'h1108);
      chk("R9 wr loaded", p_wr, TOP | 32'h1108);
      chk("R9 full after refill", 32'(p_full), 1);
      chk("R9 no xrun", 32'(p_xrun), 0);
      pcfg(3'd7, 32'hFFFF);
      chk("R9 unused code ignored rd", p_rd, 32'h1108);
      chk("R9 unused code ignored wr", p_wr, TOP | 32'h1108);

      // Sweep with software refills
      mrd = 32'h1108; mwr = TOP | 32'h1108;
      for (int i = 0; i < 60; i++) begin
         int n;
         n = ((i * 13) % 40) + 1;
         mf = m_fill(mrd, mwr, 1024);
         if (32'(n * 4) > mf) begin
            mwr = mrd ^ TOP;
            pcfg(3'd4, mwr);
            chk("R2 refill full", 32'(p_full), 1);
         end else begin
            padv(n);
            mrd = m_step(mrd, 32'(n * 4), 32'h1000, 32'h13FF);
            chk("R4 R3 sweep rd", p_rd, mrd);
            chk("R5 sweep fill", p_fill, m_fill(mrd, mwr, 1024));
            chk("R10 sweep offset", 32'(p_off), {1'b0, mrd[30:0]} - 32'h1000);
            chk("R2 sweep empty", 32'(p_empty), 32'(mrd == mwr));
         end
      end

      // R3 exact wrap onto base
      pcfg(3'd3, 32'h13F0); pcfg(3'd4, TOP | 32'h13F0);
      padv(4);
      chk("R3 wrap to base toggles", p_rd, TOP | 32'h1000);
      // R8 exact availability accepted
      pcfg(3'd4, TOP | 32'h1010);
      chk("R5 fill 16", p_fill, 16);
      padv(4);
      chk("R8 exact request accepted", p_rd, TOP | 32'h1010);
      chk("R2 empty", 32'(p_empty), 1);
      chk("R8 no underrun", 32'(p_xrun), 0);
      // R8 underrun on empty
      p_valid = 1; p_words = 1;
      #1 chk("R8 ready low on empty", 32'(p_ready), 0);
      @(negedge clk);
      p_valid = 0;
      chk("R8 rd held", p_rd, TOP | 32'h1010);
      chk("R8 underrun flagged", 32'(p_xrun), 1);
      @(negedge clk);
      chk("R8 underrun sticky", 32'(p_xrun), 1);
      prearm();
      chk("R8 rearm clears underrun", 32'(p_xrun), 0);

      // ---------------- capture channel ----------------
      ccfg(3'd0, 32'h2000); ccfg(3'd1, 32'h23FF); ccfg(3'd2, 32'h1FF);
      ccfg(3'd3, 32'h2000); ccfg(3'd4, 32'h2000);
      crearm();
      @(negedge clk);
      chk("R6 cap no mark when empty", 32'(c_hit), 0);
      cadv(64);
      chk("R4 cap wr moved", c_wr, 32'h2100); chk("R4 cap rd held", c_rd, 32'h2000);
      @(negedge clk);
      chk("R6 cap fill equal no event", 32'(c_hit), 0);
      cadv(1);
      @(negedge clk);
      chk("R6 low mark bits ignored", 32'(c_hit), 1);
      chk("R10 cap offset", 32'(c_off), 32'h104);
      cadv(191);
      chk("R2 cap full", 32'(c_full), 1);
      chk("R3 cap wrap", c_wr, TOP | 32'h2000);
      c_valid = 1; c_words = 1;
      #1 chk("R8 cap ready low on full", 32'(c_ready), 0);
      @(negedge clk);
      c_valid = 0;
      chk("R8 cap wr held", c_wr, TOP | 32'h2000);
      chk("R8 overrun flagged", 32'(c_xrun), 1);
      crearm();
      chk("R8 cap rearm clears", 32'(c_xrun), 0);

      mrd = 32'h2000; mwr = TOP | 32'h2000;
      for (int i = 0; i < 40; i++) begin
         int n;
         n = ((i * 11) % 50) + 1;
         mf = 1024 - m_fill(mrd, mwr, 1024);
         if (32'(n * 4) > mf) begin
            mrd = mwr;
            ccfg(3'd3, mrd);
            chk("R2 cap drain empty", 32'(c_empty), 1);
         end else begin
            cadv(n);
            mwr = m_step(mwr, 32'(n * 4), 32'h2000, 32'h23FF);
            chk("R4 R3 cap sweep wr", c_wr, mwr);
            chk("R5 cap sweep free", c_free, 1024 - m_fill(mrd, mwr, 1024));
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule